// File: doc/BRIEF.md
# Clock Alarm Comparator with Repeat Masks

This unit holds the alarm setting of a battery-backed time-of-day clock. Software programs four one-byte alarm fields (seconds, minutes, hours, day of month) through a byte-wide register port. Each field keeps a repeat-mask flag in its top bit, and the four flags together select how often the alarm repeats: monthly, daily, hourly, once a minute or every second. A write whose BCD value is out of range for its field is dropped, and the field keeps what it held before.

The running time arrives from an external counter as BCD fields, along with a one-second strobe. On each rising edge of that strobe the unit compares the fields that the selected repeat rate cares about. A match produces an interrupt pulse that lasts exactly one clock cycle. The time counter, the interrupt enable and any backing memory are outside this block.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 and date 0x01, and `alarm_irq` is low.
- R2: `reg_addr` selects the field: 0 is seconds, 1 is minutes, 2 is hours, 3 is date. A write takes effect on the clock edge where `reg_we` is high.
- R3: A write to seconds or minutes is stored, as the full byte, only if bits 6:0 form valid BCD digits (each nibble 0 to 9) with a value of 0 to 59. Any other write leaves the field unchanged.
- R4: A write to hours is stored, as the full byte, only if bits 5:0 are valid BCD in the range 0 to 23. Any other write leaves the field unchanged.
- R5: A write to date is stored, as the full byte, only if bits 5:0 are valid BCD and not zero. Any other write leaves the field unchanged.
- R6: `reg_rdata` is a combinational read of the addressed field and returns the stored byte unchanged, including bit 7 (the repeat mask) and bit 6.
- R7: With the mask bits of all four fields clear, the alarm fires only when date (bits 5:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) all equal the time inputs.
- R8: With only the date mask set, the alarm fires when hours, minutes and seconds match.
- R9: With the date and hours masks set and the other two clear, the alarm fires when minutes and seconds match.
- R10: With the date, hours and minutes masks set and the seconds mask clear, the alarm fires when seconds match.
- R11: Any other combination of mask bits makes the alarm fire on every strobe.
- R12: The comparison happens only on a rising edge of `tick_1hz`. A match raises `alarm_irq` in the cycle after that edge, for exactly one cycle, even when the strobe stays high longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the alarm field register port |
| reg_addr | input | 2 | Field select: 0 seconds, 1 minutes, 2 hours, 3 date |
| reg_wdata | input | 8 | Write data: bit 7 is the repeat mask, the low bits are the BCD value |
| reg_rdata | output | 8 | Stored byte of the addressed field |
| tick_1hz | input | 1 | One-second strobe from the time counter |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | Single-cycle alarm interrupt pulse |

## Verification
The assertions check on every cycle that a rejected write to seconds, hours or date leaves the field unchanged, and that an accepted seconds write stores the written byte. They also check that the interrupt is never more than one cycle wide, that it only follows a cycle in which the strobe was high, and that the every-second rate fires on each strobe edge. Which field combinations must match under the monthly, daily, hourly and per-minute rates, and how reads return the mask and spare bits, can only be shown by the bench's scenarios. Those scenarios compare the interrupt with a BCD-to-binary model of the alarm, using both random and directed times.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int FIELD_COUNT = 4;
  localparam int BYTE_W      = 8;
  localparam int MASK_BIT    = 7;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  typedef enum logic [2:0] {
    RATE_MONTH  = 3'd0,
    RATE_DAY    = 3'd1,
    RATE_HOUR   = 3'd2,
    RATE_MINUTE = 3'd3,
    RATE_SECOND = 3'd4
  } rate_e;

  // Bits of a field that carry its BCD value
  function automatic logic [BYTE_W-1:0] value_mask(input int idx);
    logic [BYTE_W-1:0] m;
    case (idx)
      F_SEC, F_MIN: m = 8'h7F;
      default:      m = 8'h3F;
    endcase
    return m;
  endfunction

  function automatic logic digits_ok(input logic [BYTE_W-1:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_bin(input logic [BYTE_W-1:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  // Range rule applied to a write into field idx
  function automatic logic field_accept(input int idx, input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] v;
    logic ok;
    v = d & value_mask(idx);
    if (!digits_ok(v)) begin
      ok = 1'b0;
    end else begin
      case (idx)
        F_SEC, F_MIN: ok = (bcd_bin(v) <= 8'd59);
        F_HOUR:       ok = (bcd_bin(v) <= 8'd23);
        default:      ok = (v != '0);
      endcase
    end
    return ok;
  endfunction

  function automatic logic [BYTE_W-1:0] reset_value(input int idx);
    return (idx == F_DATE) ? 8'h01 : 8'h00;
  endfunction

  // m = {date, hour, min, sec} mask flags
  function automatic rate_e decode_rate(input logic [FIELD_COUNT-1:0] m);
    rate_e r;
    case (m)
      4'b0000: r = RATE_MONTH;
      4'b1000: r = RATE_DAY;
      4'b1100: r = RATE_HOUR;
      4'b1110: r = RATE_MINUTE;
      default: r = RATE_SECOND;
    endcase
    return r;
  endfunction

  // Fields that must match for a rate, bit index = field index
  function automatic logic [FIELD_COUNT-1:0] care_fields(input rate_e r);
    logic [FIELD_COUNT-1:0] c;
    case (r)
      RATE_MONTH:  c = 4'b1111;
      RATE_DAY:    c = 4'b0111;
      RATE_HOUR:   c = 4'b0011;
      RATE_MINUTE: c = 4'b0001;
      default:     c = 4'b0000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_REGS = FIELD_COUNT,
  parameter int DATA_W   = BYTE_W,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o,
  output logic [NUM_REGS-1:0]              wr_hit,
  output logic [NUM_REGS-1:0]              wr_ok
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_field
    assign wr_hit[i] = we && (addr == ADDR_W'(i));
    assign wr_ok[i]  = field_accept(i, wdata);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= reset_value(i);
      end else if (wr_hit[i] && wr_ok[i]) begin
        regs_q[i] <= wdata;
      end
    end

    assign regs_o[i] = regs_q[i];
  end

  assign rdata = regs_q[addr];

endmodule

// File: rtl/alarm_rate_dec.sv
module alarm_rate_dec
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_REGS = FIELD_COUNT,
  parameter int DATA_W   = BYTE_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output rate_e                           rate_o,
  output logic [NUM_REGS-1:0]             care_o
);

  logic [NUM_REGS-1:0] mask_bits;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_mask
    assign mask_bits[i] = regs[i][MASK_BIT];
  end

  always_comb begin
    rate_o = decode_rate(mask_bits);
    care_o = care_fields(rate_o);
  end

endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_REGS = FIELD_COUNT,
  parameter int DATA_W   = BYTE_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] now,
  input  logic [NUM_REGS-1:0]             care,
  input  logic                            tick,
  output logic [NUM_REGS-1:0]             field_eq,
  output logic                            tick_rise,
  output logic                            hit,
  output logic                            irq
);

  logic tick_q;
  logic irq_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    assign field_eq[i] = ((regs[i] ^ now[i]) & value_mask(i)) == '0;
  end

  assign tick_rise = tick && !tick_q;
  assign hit       = &(field_eq | ~care);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tick_q <= tick;
      irq_q  <= tick_rise && hit;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_REGS = FIELD_COUNT,
  parameter int DATA_W   = BYTE_W,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_1hz,
  input  logic [6:0]        now_sec,
  input  logic [6:0]        now_min,
  input  logic [5:0]        now_hour,
  input  logic [5:0]        now_date,
  output logic              alarm_irq
);

  logic [NUM_REGS-1:0][DATA_W-1:0] alarm_regs;
  logic [NUM_REGS-1:0][DATA_W-1:0] now_fields;
  logic [NUM_REGS-1:0]             wr_hit;
  logic [NUM_REGS-1:0]             wr_ok;
  logic [NUM_REGS-1:0]             care;
  logic [NUM_REGS-1:0]             field_eq;
  logic                            tick_rise;
  logic                            match_hit;
  rate_e                           rate_sel;

  always_comb begin
    now_fields         = '0;
    now_fields[F_SEC]  = DATA_W'(now_sec);
    now_fields[F_MIN]  = DATA_W'(now_min);
    now_fields[F_HOUR] = DATA_W'(now_hour);
    now_fields[F_DATE] = DATA_W'(now_date);
  end

  alarm_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .regs_o (alarm_regs),
    .wr_hit (wr_hit),
    .wr_ok  (wr_ok)
  );

  alarm_rate_dec #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rate (
    .regs   (alarm_regs),
    .rate_o (rate_sel),
    .care_o (care)
  );

  alarm_matcher #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .regs      (alarm_regs),
    .now       (now_fields),
    .care      (care),
    .tick      (tick_1hz),
    .field_eq  (field_eq),
    .tick_rise (tick_rise),
    .hit       (match_hit),
    .irq       (alarm_irq)
  );

endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk
  import rtc_alarm_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic [1:0]              reg_addr,
  input logic [7:0]              reg_wdata,
  input logic                    tick_1hz,
  input logic                    alarm_irq,
  input logic [3:0][7:0]         regs,
  input rate_e                   rate
);

  logic tick_prev;
  logic sec_ok, hour_ok, date_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_prev <= 1'b0;
    else        tick_prev <= tick_1hz;
  end

  assign sec_ok  = (reg_wdata[3:0] <= 4'd9) && (reg_wdata[6:4] <= 3'd5);
  assign hour_ok = (reg_wdata[3:0] <= 4'd9) &&
                   ((reg_wdata[5:4] < 2'd2) || (reg_wdata[5:4] == 2'd2 && reg_wdata[3:0] <= 4'd3));
  assign date_ok = (reg_wdata[3:0] <= 4'd9) && (reg_wdata[5:0] != 6'd0);

  // R3
  sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && !sec_ok) |=> $stable(regs[0]));

  // R3
  sec_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && sec_ok) |=> (regs[0] == $past(reg_wdata)));

  // R4
  hour_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && !hour_ok) |=> $stable(regs[2]));

  // R5
  date_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && !date_ok) |=> $stable(regs[3]));

  // R11
  every_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_SECOND && tick_1hz && !tick_prev) |=> alarm_irq);

  // R12
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |=> !alarm_irq);

  // R12
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(tick_1hz));

endmodule

bind rtc_alarm_unit alarm_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tick_1hz  (tick_1hz),
  .alarm_irq (alarm_irq),
  .regs      (alarm_regs),
  .rate      (rate_sel)
);

// File: tb/sim_rtc_alarm_unit.sv
module sim_rtc_alarm_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_1hz = 1'b0;
  logic [6:0] now_sec = '0;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic [5:0] now_date = 6'h01;
  logic       alarm_irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  rtc_alarm_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_1hz(tick_1hz),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .alarm_irq(alarm_irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int to_int(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic tb_accept(input int a, input logic [7:0] d);
    logic [7:0] v;
    v = (a < 2) ? (d & 8'h7F) : (d & 8'h3F);
    if (v[3:0] > 4'd9) return 1'b0;
    if (a < 2)  return to_int(v) < 60;
    if (a == 2) return to_int(v) < 24;
    return to_int(v) != 0;
  endfunction

  function automatic logic tb_fire(input int s, input int m, input int h, input int d);
    logic ms, mm, mh, md, es, em, eh, ed;
    ms = model[0][7]; mm = model[1][7]; mh = model[2][7]; md = model[3][7];
    es = to_int(model[0] & 8'h7F) == s;
    em = to_int(model[1] & 8'h7F) == m;
    eh = to_int(model[2] & 8'h3F) == h;
    ed = to_int(model[3] & 8'h3F) == d;
    if (!md && !mh && !mm && !ms) return es && em && eh && ed;
    if (md && !mh && !mm && !ms)  return es && em && eh;
    if (md && mh && !mm && !ms)   return es && em;
    if (md && mh && mm && !ms)    return es;
    return 1'b1;
  endfunction

  task automatic write_reg(input int a, input logic [7:0] d, input string req);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (tb_accept(a, d)) model[a] = d;
    reg_addr = 2'(a);
    #1;
    check(reg_rdata == model[a], req, reg_rdata, model[a]);
  endtask

  task automatic tick_at(input int s, input int m, input int h, input int d, input string req);
    logic exp;
    @(negedge clk);
    now_sec = 7'(to_bcd(s)); now_min = 7'(to_bcd(m));
    now_hour = 6'(to_bcd(h)); now_date = 6'(to_bcd(d));
    tick_1hz = 1'b1;
    exp = tb_fire(s, m, h, d);
    @(negedge clk);
    tick_1hz = 1'b0;
    check(alarm_irq == exp, req, alarm_irq, exp);
    @(negedge clk);
    check(alarm_irq == 1'b0, "R12 pulse width", alarm_irq, 0);
  endtask

  task automatic set_alarm(input int s, input int m, input int h, input int d, input logic [3:0] mk);
    write_reg(0, {mk[0], to_bcd(s)[6:0]}, "R3 setup");
    write_reg(1, {mk[1], to_bcd(m)[6:0]}, "R3 setup");
    write_reg(2, {mk[2], to_bcd(h)[6:0]}, "R4 setup");
    write_reg(3, {mk[3], to_bcd(d)[6:0]}, "R5 setup");
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model[0] = 8'h00; model[1] = 8'h00; model[2] = 8'h00; model[3] = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values, R2 field addressing, R6 read path
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check(reg_rdata == model[a], "R1 reset value", reg_rdata, model[a]);
    end
    check(alarm_irq == 1'b0, "R1 irq low", alarm_irq, 0);

    // R3 boundaries
    write_reg(0, 8'h59, "R3 sec 59 accepted");
    write_reg(0, 8'h60, "R3 sec 60 rejected");
    write_reg(0, 8'h4A, "R3 sec bad digit rejected");
    write_reg(1, 8'hD9, "R3 min mask+59 accepted");
    // R4 boundaries
    write_reg(2, 8'h23, "R4 hour 23 accepted");
    write_reg(2, 8'h24, "R4 hour 24 rejected");
    write_reg(2, 8'hC5, "R6 hour bit6 kept");
    // R5 boundaries
    write_reg(3, 8'h00, "R5 date 0 rejected");
    write_reg(3, 8'h1C, "R5 date bad digit rejected");
    write_reg(3, 8'h31, "R5 date 31 accepted");

    // R7 monthly
    set_alarm(30, 15, 10, 12, 4'b0000);
    tick_at(30, 15, 10, 12, "R7 monthly hit");
    tick_at(30, 15, 10, 13, "R7 monthly date miss");
    // R8 daily
    set_alarm(5, 6, 7, 20, 4'b1000);
    tick_at(5, 6, 7, 3, "R8 daily hit other date");
    tick_at(5, 6, 8, 20, "R8 daily hour miss");
    // R9 hourly
    set_alarm(45, 59, 0, 1, 4'b1100);
    tick_at(45, 59, 17, 9, "R9 hourly hit");
    tick_at(45, 58, 17, 9, "R9 hourly min miss");
    // R10 once a minute
    set_alarm(1, 2, 3, 4, 4'b1110);
    tick_at(1, 40, 22, 28, "R10 minute hit");
    tick_at(2, 40, 22, 28, "R10 minute sec miss");
    // R11 other combinations
    set_alarm(1, 2, 3, 4, 4'b0001);
    tick_at(50, 50, 20, 20, "R11 sec-mask only fires");
    set_alarm(1, 2, 3, 4, 4'b0100);
    tick_at(9, 9, 9, 9, "R11 hour-mask only fires");

    // R12 held strobe gives one pulse; no strobe gives none
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    check(alarm_irq == 1'b1, "R12 held strobe first", alarm_irq, 1);
    @(negedge clk);
    check(alarm_irq == 1'b0, "R12 held strobe once", alarm_irq, 0);
    tick_1hz = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(alarm_irq == 1'b0, "R12 no strobe no irq", alarm_irq, 0);
    end

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 4) begin
        int a;
        logic [7:0] d;
        a = int'($urandom_range(0, 3));
        if ($urandom_range(0, 1) == 0) d = 8'($urandom);
        else begin
          case (a)
            0, 1: d = to_bcd(int'($urandom_range(0, 59)));
            2:    d = to_bcd(int'($urandom_range(0, 23)));
            default: d = to_bcd(int'($urandom_range(1, 31)));
          endcase
          d[7] = ($urandom_range(0, 2) != 0);
        end
        write_reg(a, d, "R3 R4 R5 random write");
      end else begin
        int s, m, h, d;
        s = to_int(model[0] & 8'h7F); m = to_int(model[1] & 8'h7F);
        h = to_int(model[2] & 8'h3F); d = to_int(model[3] & 8'h3F);
        if ($urandom_range(0, 3) == 0) s = int'($urandom_range(0, 59));
        if ($urandom_range(0, 3) == 0) m = int'($urandom_range(0, 59));
        if ($urandom_range(0, 3) == 0) h = int'($urandom_range(0, 23));
        if ($urandom_range(0, 3) == 0) d = int'($urandom_range(1, 39));
        tick_at(s, m, h, d, "R7 R8 R9 R10 R11 random tick");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule